// File: doc/BRIEF.md
# Two-Cell Bleed Balancing Controller

This block decides when to switch on a bleed (bypass) load across one of two cells wired in series. It receives the two cell voltages as unsigned millivolt codes from an upstream converter, a sample-valid strobe that marks a fresh pair of readings, and an enable from the charge sequencer. The sequencer raises the enable during the constant-voltage phase of charging. The block drives two active-high bypass outputs, one for each cell.

Balancing is armed only while at least one cell reads above a voltage floor. When armed, the block bleeds the higher cell if the two cells differ by at least a margin. Once a cell is being bled, the bleed stays on until the difference falls below a release level, which is half the margin. This hysteresis stops the output from toggling when the difference sits near the margin. The block never bleeds both cells at once, and the bypass transistors are outside the block.

Top module: `cell_bal_ctrl`

## Requirements
- R1: While reset is high, both bypass outputs are low, and they are still low on the first cycle after reset is released.
- R2: With the enable high and the strobe low, the bypass outputs keep their value across a clock edge. Outputs change only on an edge where the strobe is high.
- R3: If the enable is low at a clock edge, both bypass outputs are low after that edge, whatever the strobe and the voltages are.
- R4: On a strobe edge with the enable high, both outputs go low if neither cell is strictly above ARM_MV (default 4135 mV). A cell reading exactly 4135 does not arm balancing.
- R5: On an armed strobe edge, if the cells differ by MARGIN_MV (default 20 mV) or more, the output of the higher cell goes high and the output of the lower cell goes low. Output bit 0 belongs to cell 1 (`cell1_mv`) and bit 1 belongs to cell 2 (`cell2_mv`).
- R6: On an armed strobe edge with no bleed active, a difference of less than MARGIN_MV (for example 19 mV) leaves both outputs low.
- R7: On an armed strobe edge, an active bleed stays on if its cell is still the higher one and the difference is at least MARGIN_MV/2 (default 10 mV).
- R8: On an armed strobe edge, an active bleed turns off when the difference drops below MARGIN_MV/2, or when its cell is no longer the higher one.
- R9: The two bypass outputs are never high at the same time, and a high output never belongs to the cell that read lower on the strobe that set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Marks a fresh pair of cell readings |
| bal_en | input | 1 | Balancing enable from the charge sequencer |
| cell1_mv | input | VW | Cell 1 (low-side) voltage in mV |
| cell2_mv | input | VW | Cell 2 (high-side) voltage in mV |
| bypass | output | 2 | Bypass drive; bit 0 cell 1, bit 1 cell 2 |

## Verification
The bench builds the block with its default parameters: a 13-bit voltage code, a 4135 mV arming floor and a 20 mV margin, which gives a 10 mV release level. Random readings are drawn around the floor with differences of 0 to 39 mV. This puts every region within reach: readings just below and just above the floor, differences inside the hysteresis band, and differences on both sides of the margin. Directed steps hit the exact edges at 4135 mV, 19 mV, 20 mV, 10 mV and 9 mV, and also cover a swap of which cell is higher.

// File: rtl/cell_bal_pkg.sv
package cell_bal_pkg;
  localparam int NCELL = 2;
  typedef logic [NCELL-1:0] cell_vec_t;
  localparam cell_vec_t NO_BLEED = '0;
endpackage

// File: rtl/cell_bal_diff.sv
module cell_bal_diff #(
  parameter int VW = 13
) (
  input  logic [VW-1:0] v1,
  input  logic [VW-1:0] v2,
  output logic [VW-1:0] mag,
  output logic [1:0]    higher
);
  always_comb begin
    higher[0] = (v1 > v2);
    higher[1] = (v2 > v1);
    if (v1 >= v2) mag = v1 - v2;
    else          mag = v2 - v1;
  end
endmodule

// File: rtl/cell_bal_arm.sv
module cell_bal_arm #(
  parameter int VW     = 13,
  parameter int ARM_MV = 4135
) (
  input  logic [VW-1:0] v1,
  input  logic [VW-1:0] v2,
  output logic          armed
);
  localparam logic [VW-1:0] FLOOR = VW'(ARM_MV);
  logic [1:0] above;
  logic [VW-1:0] vin [2];
  assign vin[0] = v1;
  assign vin[1] = v2;

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    assign above[g] = (vin[g] > FLOOR);
  end

  assign armed = |above;
endmodule

// File: rtl/cell_bal_state.sv
module cell_bal_state
  import cell_bal_pkg::*;
#(
  parameter int VW        = 13,
  parameter int MARGIN_MV = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_valid,
  input  logic          bal_en,
  input  logic          armed,
  input  logic [VW-1:0] mag,
  input  logic [1:0]    higher,
  output cell_vec_t     bleed
);
  localparam logic [VW-1:0] ON_LVL  = VW'(MARGIN_MV);
  localparam logic [VW-1:0] OFF_LVL = VW'(MARGIN_MV / 2);

  cell_vec_t nxt;
  logic      keep;

  always_comb begin
    keep = ((bleed & higher) != NO_BLEED) && (mag >= OFF_LVL);
    nxt  = NO_BLEED;
    if (armed) begin
      if (mag >= ON_LVL)  nxt = higher;
      else if (keep)      nxt = bleed;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               bleed <= NO_BLEED;
    else if (!bal_en)      bleed <= NO_BLEED;
    else if (sample_valid) bleed <= nxt;
  end

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(bleed[0] && bleed[1])); // R9
  AST_EN_OFF: assert property (@(posedge clk) disable iff (rst)
    !bal_en |=> (bleed == NO_BLEED)); // R3
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (bal_en && !sample_valid) |=> $stable(bleed)); // R2
  AST_DISARM_OFF: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && !armed) |=> (bleed == NO_BLEED)); // R4
  AST_BIG_GAP: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && bal_en && armed && mag >= ON_LVL) |=> (bleed == $past(higher))); // R5
  AST_SMALL_GAP_OFF: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && armed && mag < OFF_LVL) |=> (bleed == NO_BLEED)); // R8
endmodule

// File: rtl/cell_bal_ctrl.sv
module cell_bal_ctrl
  import cell_bal_pkg::*;
#(
  parameter int VW        = 13,
  parameter int ARM_MV    = 4135,
  parameter int MARGIN_MV = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_valid,
  input  logic          bal_en,
  input  logic [VW-1:0] cell1_mv,
  input  logic [VW-1:0] cell2_mv,
  output logic [1:0]    bypass
);
  logic [VW-1:0] mag;
  logic [1:0]    higher;
  logic          armed;
  cell_vec_t     bleed;

  cell_bal_diff #(.VW(VW)) u_diff (
    .v1(cell1_mv), .v2(cell2_mv), .mag(mag), .higher(higher)
  );

  cell_bal_arm #(.VW(VW), .ARM_MV(ARM_MV)) u_arm (
    .v1(cell1_mv), .v2(cell2_mv), .armed(armed)
  );

  cell_bal_state #(.VW(VW), .MARGIN_MV(MARGIN_MV)) u_state (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .bal_en(bal_en),
    .armed(armed), .mag(mag), .higher(higher), .bleed(bleed)
  );

  assign bypass = bleed;

  AST_NOT_LOWER_CELL: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && bal_en) |=> !(bypass[0] && ($past(cell1_mv) < $past(cell2_mv)))); // R9
endmodule

// File: tb/cell_bal_ctrl_test.sv
module cell_bal_ctrl_test;
  localparam int VW = 13;
  localparam int ARM = 4135;
  localparam int MRG = 20;

  logic clk = 0;
  logic rst = 1;
  logic sv = 0;
  logic en = 0;
  logic [VW-1:0] v1 = '0;
  logic [VW-1:0] v2 = '0;
  logic [1:0] byp;
  logic [1:0] cur = 2'b00;
  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cell_bal_ctrl #(.VW(VW), .ARM_MV(ARM), .MARGIN_MV(MRG)) uut (
    .clk(clk), .rst(rst), .sample_valid(sv), .bal_en(en),
    .cell1_mv(v1), .cell2_mv(v2), .bypass(byp)
  );

  function automatic logic [1:0] model(logic [1:0] c, logic s, logic e, int a, int b);
    int m;
    if (!e) return 2'b00;
    if (!s) return c;
    if (!(a > ARM || b > ARM)) return 2'b00;
    m = (a > b) ? a - b : b - a;
    if (m >= MRG) return (a > b) ? 2'b01 : 2'b10;
    if (m >= MRG / 2 && ((c[0] && a > b) || (c[1] && b > a))) return c;
    return 2'b00;
  endfunction

  task automatic chk(logic [1:0] exp, string tag);
    checks++;
    if (byp !== exp) begin
      bad++;
      $display("FAIL %s: bypass=%b expected=%b", tag, byp, exp);
    end
  endtask

  task automatic step(logic s, logic e, int a, int b, string tag);
    @(negedge clk);
    sv = s; en = e; v1 = VW'(a); v2 = VW'(b);
    cur = model(cur, s, e, a, b);
    @(negedge clk);
    chk(cur, tag);
    if (byp[0] && byp[1]) begin
      bad++;
      $display("FAIL R9: bypass=%b expected=not 11", byp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: bypass=%b expected=finish", byp);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(2'b00, "R1 in reset");
    rst = 0;
    @(negedge clk);
    chk(2'b00, "R1 after reset");

    step(1, 1, 4135, 4100, "R4 floor exact");
    chk(2'b00, "R4 explicit");
    step(1, 1, 4136, 4116, "R5 cell1 high by 20");
    chk(2'b01, "R5 explicit");
    step(0, 1, 4000, 4000, "R2 hold without strobe");
    chk(2'b01, "R2 explicit");
    step(1, 1, 4160, 4150, "R7 hold at 10");
    chk(2'b01, "R7 explicit");
    step(1, 1, 4160, 4151, "R8 release at 9");
    chk(2'b00, "R8 explicit");
    step(1, 1, 4160, 4179, "R6 gap 19 idle");
    chk(2'b00, "R6 explicit");
    step(1, 1, 4150, 4175, "R5 cell2 high");
    chk(2'b10, "R5 cell2 explicit");
    step(1, 1, 4170, 4155, "R8 swap higher cell");
    chk(2'b00, "R8 swap explicit");
    step(1, 1, 4150, 4175, "R5 reassert");
    step(0, 0, 4150, 4175, "R3 enable low");
    chk(2'b00, "R3 explicit");
    step(1, 1, 4150, 4175, "R5 reassert2");
    step(1, 1, 4100, 4130, "R4 disarm");
    chk(2'b00, "R4 disarm explicit");

    for (int i = 0; i < 4000; i++) begin
      int a, b, d;
      logic s, e;
      a = 4100 + int'($urandom % 80);
      d = int'($urandom % 40);
      b = ($urandom % 2) ? a + d : a - d;
      s = ($urandom % 10) < 7;
      e = ($urandom % 10) != 0;
      step(s, e, a, b, "R2/R3/R4/R5/R6/R7/R8 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule